// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Controller

This block is a bus master that runs one 32-bit read or write request, with four byte enables, on an external bus whose data width the slave picks for each cycle. Every cycle starts as if the bus were 32 bits wide. The slave's active-low half-width input is sampled in the clock where active-low ready ends the second bus state. A negated sample means the whole transfer is complete. An asserted sample means the bus is 16 bits wide, and the upper bytes may then need a second, separately acknowledged cycle.

A cycle is one address state, with the strobe low, followed by one or more data states. The data state repeats while ready stays high. When a request has only upper bytes enabled, that data moves on data lines 0–15. The bus returns to idle for at least one clock between transfers. The core side is a plain request and done handshake. The read result is registered and updated as each half completes.

Top module: `bus_size_ctrl`

## Requirements
- R1: While reset is held, `bus_ads_n` is 1, `bus_be_n` is 4'b1111, `bus_wr` is 0, `done` is 0 and `rdata` is 0.
- R2: A request seen while idle starts an address state on the next clock. In that state `bus_ads_n` is low for exactly one clock, `bus_addr` shows the request address, `bus_be_n` is the inverse of the request enables, and `bus_wr` is the request direction. A data state with `bus_ads_n` high follows.
- R3: If `bus_rdy_n` is high at the end of a data state, that state repeats, and address, enables and direction are held.
- R4: If `bus_half_n` is high in the clock where `bus_rdy_n` is low, the transfer finishes with that single cycle.
- R5: If `bus_half_n` is low at acknowledge, and both a lower enable (bit 0 or 1) and an upper enable (bit 2 or 3) are set, a second address state follows at once. Its `bus_be_n[1:0]` is 2'b11 and its `bus_be_n[3:2]` is the inverse of the request's upper enables.
- R6: The second cycle samples `bus_half_n` again. If it is high there, the upper bytes come from `bus_din[31:16]`.
- R7: On a 16-bit answer, when the current enables include no lower byte, `bus_din[15:0]` is stored into the enabled bytes of `rdata[31:16]`.
- R8: A 16-bit answer for a request with only lower enables ends the transfer with no second cycle.
- R9: While busy, if the current enables have no lower byte, `bus_dout` is {wdata[31:16], wdata[31:16]}. Otherwise it is wdata unchanged.
- R10: `done` is high for exactly one clock, the clock after the final acknowledge. In that clock the bus is idle (`bus_ads_n` 1, `bus_be_n` 4'b1111).
- R11: `rdata` is cleared when a request is accepted. Each acknowledged read cycle updates only the enabled bytes it carries. A 16-bit answer with lower bytes enabled ignores `bus_din[31:16]`.
- R12: Request inputs are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_be | input | 4 | Byte enables, active high |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Registered read result |
| bus_ads_n | output | 1 | Address strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_be_n | output | 4 | Bus byte enables, active low |
| bus_wr | output | 1 | Bus direction, 1 = write |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_rdy_n | input | 1 | Ready acknowledge, active low |
| bus_half_n | input | 1 | Half-width select, active low |

## Verification
A wrong phase shows up at the ports in the very next clock: as an extra or missing strobe pulse, a changed enable pattern during a wait, or `done` arriving early or late. A wrong split decision or a stale size sample shows up as a wrong strobe count, and one clock later as wrong bytes in `rdata`. A lane-steering fault shows up at once on `bus_dout`, or in `rdata` in the clock after the acknowledge. A reference model compares every clock, so any of these faults is reported within one clock of its cause.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int NBYTES = 4;
  localparam int DW     = NBYTES * 8;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_ADDR = 2'd1, PH_DATA = 2'd2} bus_ph_t;

  // A 16-bit answer on a request spanning both halves needs a second cycle.
  function automatic logic need_split(input logic [NBYTES-1:0] be, input logic half);
    return half && (|be[1:0]) && (|be[3:2]);
  endfunction

  function automatic logic [NBYTES-1:0] keep_upper(input logic [NBYTES-1:0] be);
    return {be[3:2], 2'b00};
  endfunction

  // Upper-only enables: mirror upper write bytes onto the low lanes.
  function automatic logic [DW-1:0] steer_wr(input logic [DW-1:0] w, input logic [NBYTES-1:0] be);
    return (be[1:0] == 2'b00) ? {w[31:16], w[31:16]} : w;
  endfunction

  function automatic logic [DW-1:0] merge_rd(input logic [DW-1:0] old, input logic [DW-1:0] din,
                                             input logic [NBYTES-1:0] be, input logic half);
    logic [DW-1:0] src;
    logic [DW-1:0] res;
    logic          take;
    src = (half && be[1:0] == 2'b00) ? {din[15:0], din[15:0]} : din;
    res = old;
    for (int i = 0; i < NBYTES; i++) begin
      take = be[i] && (!half || i < 2 || be[1:0] == 2'b00);
      if (take) res[i*8 +: 8] = src[i*8 +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/bsz_seq.sv
module bsz_seq
  import bsz_pkg::*;
#(
  parameter int AW = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [NBYTES-1:0] req_be,
  input  logic [DW-1:0]     req_wdata,
  input  logic              bus_rdy_n,
  input  logic              bus_half_n,
  output logic              bus_ads_n,
  output logic [AW-1:0]     bus_addr,
  output logic [NBYTES-1:0] bus_be_n,
  output logic              bus_wr,
  output logic              busy,
  output logic [NBYTES-1:0] cur_be,
  output logic [DW-1:0]     wdata_q,
  output logic              accept_evt,
  output logic              cap_evt,
  output logic              half_ans,
  output logic              done
);
  bus_ph_t           ph;
  logic [AW-1:0]     addr_q;
  logic [NBYTES-1:0] be_q;
  logic              wr_q;
  logic              ack_evt, split_evt, final_evt;

  assign accept_evt = (ph == PH_IDLE) && req_valid;
  assign ack_evt    = (ph == PH_DATA) && !bus_rdy_n;
  assign half_ans   = !bus_half_n;
  assign split_evt  = ack_evt && need_split(be_q, half_ans);
  assign final_evt  = ack_evt && !split_evt;
  assign cap_evt    = ack_evt && !wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      addr_q  <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= final_evt;
      unique case (ph)
        PH_IDLE: if (req_valid) begin
          ph      <= PH_ADDR;
          addr_q  <= req_addr;
          be_q    <= req_be;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
        end
        PH_ADDR: ph <= PH_DATA;
        PH_DATA: if (split_evt) begin
          ph   <= PH_ADDR;
          be_q <= keep_upper(be_q);
        end else if (final_evt) begin
          ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (ph != PH_IDLE);
  assign bus_ads_n = (ph != PH_ADDR);
  assign bus_addr  = addr_q;
  assign bus_be_n  = busy ? ~be_q : '1;
  assign bus_wr    = busy && wr_q;
  assign cur_be    = be_q;

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ads_n |=> bus_ads_n);
  p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA && bus_rdy_n) |=> (bus_ads_n && busy && $stable(bus_be_n) && $stable(bus_addr) && $stable(bus_wr)));
  p_split_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    split_evt |=> (!bus_ads_n && bus_be_n[1:0] == 2'b11));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_final_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    final_evt |=> (done && bus_be_n == 4'hF && bus_ads_n));
  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack_evt && ph != PH_ADDR) |=> $stable(bus_addr));
endmodule

// File: rtl/bsz_lanes.sv
module bsz_lanes
  import bsz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic              half,
  input  logic [NBYTES-1:0] cur_be,
  input  logic [DW-1:0]     wdata_q,
  input  logic [DW-1:0]     bus_din,
  output logic [DW-1:0]     bus_dout,
  output logic [DW-1:0]     rdata
);
  logic lower_half_cap;

  assign bus_dout       = steer_wr(wdata_q, cur_be);
  assign lower_half_cap = cap && half && (cur_be[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n)   rdata <= '0;
    else if (clr) rdata <= '0;
    else if (cap) rdata <= merge_rd(rdata, bus_din, cur_be, half);
  end

  p_half_upper_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lower_half_cap |=> (rdata[31:16] == $past(rdata[31:16])));
  p_clear_on_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rdata == '0));
endmodule

// File: rtl/bus_size_ctrl.sv
module bus_size_ctrl
  import bsz_pkg::*;
#(
  parameter int AW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_be,
  input  logic [31:0]   req_wdata,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          bus_ads_n,
  output logic [AW-1:0] bus_addr,
  output logic [3:0]    bus_be_n,
  output logic          bus_wr,
  output logic [31:0]   bus_dout,
  input  logic [31:0]   bus_din,
  input  logic          bus_rdy_n,
  input  logic          bus_half_n
);
  logic              busy, accept_evt, cap_evt, half_ans;
  logic [NBYTES-1:0] cur_be;
  logic [DW-1:0]     wdata_q;

  bsz_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .bus_rdy_n(bus_rdy_n), .bus_half_n(bus_half_n),
    .bus_ads_n(bus_ads_n), .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wr(bus_wr),
    .busy(busy), .cur_be(cur_be), .wdata_q(wdata_q),
    .accept_evt(accept_evt), .cap_evt(cap_evt), .half_ans(half_ans), .done(done)
  );

  bsz_lanes u_lanes (
    .clk(clk), .rst_n(rst_n),
    .clr(accept_evt), .cap(cap_evt), .half(half_ans),
    .cur_be(cur_be), .wdata_q(wdata_q), .bus_din(bus_din),
    .bus_dout(bus_dout), .rdata(rdata)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_ads_n && bus_be_n == 4'hF && !bus_wr));
endmodule

// File: tb/sim_bus_size_ctrl.sv
`timescale 1ns/100ps
module sim_bus_size_ctrl;
  localparam int AW = 30;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0, bus_din = '0;
  logic bus_rdy_n = 1, bus_half_n = 1;
  logic done, bus_ads_n, bus_wr;
  logic [31:0] rdata, bus_dout;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_be_n;

  int vectors = 0, fails = 0;

  always #2.5 clk = ~clk;

  bus_size_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_ads_n(bus_ads_n), .bus_addr(bus_addr),
    .bus_be_n(bus_be_n), .bus_wr(bus_wr), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_rdy_n(bus_rdy_n), .bus_half_n(bus_half_n)
  );

  // reference model state
  int m_ph = 0, m_wcnt = 0;
  bit m_pass = 0, m_wr = 0, m_done = 0;
  logic [AW-1:0] m_addr = '0;
  logic [3:0] m_be = '0;
  logic [31:0] m_wd = '0, m_rd = '0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] bmerge(input logic [31:0] old, input logic [31:0] d,
                                         input logic [3:0] be, input bit h16);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) begin
      if (!be[i]) continue;
      if (!h16 || i < 2) r[8*i +: 8] = d[8*i +: 8];
      else if (be[1:0] == 0) r[8*i +: 8] = d[8*(i-2) +: 8];
    end
    return r;
  endfunction

  task automatic model_step();
    m_done = 0;
    case (m_ph)
      0: if (req_valid) begin
        m_wr = req_write; m_addr = req_addr; m_be = req_be; m_wd = req_wdata;
        m_rd = 0; m_pass = 0; m_ph = 1;
      end
      1: begin m_ph = 2; m_wcnt = 0; end
      default: if (!bus_rdy_n) begin
        if (!m_wr) m_rd = bmerge(m_rd, bus_din, m_be, !bus_half_n);
        if (!bus_half_n && m_be[1:0] != 0 && m_be[3:2] != 0) begin
          m_be = {m_be[3:2], 2'b00}; m_pass = 1; m_ph = 1;
        end else begin
          m_ph = 0; m_done = 1;
        end
      end else m_wcnt++;
    endcase
  endtask

  task automatic compare_all();
    chk("R2 strobe", {31'd0, bus_ads_n}, {31'd0, m_ph != 1});
    chk("R2/R3 enables", {28'd0, bus_be_n}, {28'd0, (m_ph == 0) ? 4'hF : ~m_be});
    chk("R2 direction", {31'd0, bus_wr}, {31'd0, m_ph != 0 && m_wr});
    chk("R10 done", {31'd0, done}, {31'd0, m_done});
    chk("R11 rdata", rdata, m_rd);
    if (m_ph != 0) begin
      chk("R2 addr", {2'd0, bus_addr}, {2'd0, m_addr});
      chk("R9 dout", bus_dout, (m_be[1:0] == 0) ? {m_wd[31:16], m_wd[31:16]} : m_wd);
    end
  endtask

  // independent end result for a read
  function automatic logic [31:0] final_rd(input logic [3:0] be, input bit h1, input bit h2,
                                           input logic [31:0] d1, input logic [31:0] d2);
    logic [31:0] r = 0;
    logic [31:0] up;
    for (int i = 0; i < 4; i++) if (be[i]) begin
      if (!h1) r[8*i +: 8] = d1[8*i +: 8];
      else if (i < 2) r[8*i +: 8] = d1[8*i +: 8];
      else begin
        up = (be[1:0] == 0) ? d1 : d2;
        if (be[1:0] == 0 || h2) r[8*i +: 8] = up[8*(i-2) +: 8];
        else r[8*i +: 8] = d2[8*i +: 8];
      end
    end
    return r;
  endfunction

  task automatic txn(input string tag, input bit wr, input logic [AW-1:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input bit h1, input bit h2,
                     input logic [31:0] d1, input logic [31:0] d2, input int waits);
    int ads_cnt = 0;
    int cyc = 0;
    bit fin = 0;
    int exp_cnt;
    exp_cnt = (h1 && be[1:0] != 0 && be[3:2] != 0) ? 2 : 1;
    req_write = wr; req_addr = a; req_be = be; req_wdata = wd; req_valid = 1;
    while (!fin && cyc < 200) begin
      @(posedge clk); model_step(); cyc++;
      @(negedge clk);
      compare_all();
      if (!bus_ads_n) ads_cnt++;
      if (m_ph != 0) begin // R12: junk on the request side while busy
        req_write = !wr; req_addr = ~a; req_be = ~be; req_wdata = ~wd;
      end
      if (m_done) begin req_valid = 0; fin = 1; end
      bus_rdy_n  = !(m_ph == 2 && m_wcnt >= waits);
      bus_half_n = m_pass ? !h2 : !h1;
      bus_din    = m_pass ? d2 : d1;
    end
    if (!fin) begin fails++; $display("FAIL %s watchdog act=hung exp=done", tag); end
    chk({tag, " cycle count"}, ads_cnt, exp_cnt);
    chk({tag, " result R12"}, rdata, wr ? 32'h0 : final_rd(be, h1, h2, d1, d2));
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ads", {31'd0, bus_ads_n}, 32'd1);
    chk("R1 be", {28'd0, bus_be_n}, 32'hF);
    chk("R1 wr", {31'd0, bus_wr}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rst_n = 1;
    @(negedge clk);
    txn("R4 full 32", 0, 30'h100, 4'hF, 0, 0, 0, 32'hA1B2C3D4, 32'h0, 0);
    txn("R5 R7 split 16/16", 0, 30'h104, 4'hF, 0, 1, 1, 32'h11112222, 32'h33334444, 0);
    txn("R6 split 16/32", 0, 30'h108, 4'hF, 0, 1, 0, 32'h55556666, 32'h77778888, 1);
    txn("R7 upper only", 0, 30'h10C, 4'hC, 0, 1, 1, 32'h9999AAAA, 32'h0, 0);
    txn("R8 lower only 16", 0, 30'h110, 4'h3, 0, 1, 1, 32'hBBBBCCCC, 32'h0, 0);
    txn("R3 R9 write split", 1, 30'h114, 4'hF, 32'hDEADBEEF, 1, 1, 0, 0, 2);
    txn("R9 write upper", 1, 30'h118, 4'h4, 32'h12345678, 1, 1, 0, 0, 0);
    txn("R11 mid bytes", 0, 30'h11C, 4'h6, 0, 1, 0, 32'hCAFEF00D, 32'h0BADC0DE, 1);
    txn("R4 write byte0", 1, 30'h120, 4'h1, 32'h000000EE, 0, 0, 0, 0, 3);
    txn("R11 lower 32 on 16", 0, 30'h124, 4'h9, 0, 1, 1, 32'hFEDCBA98, 32'h76543210, 0);
    // R10 idle clock after done
    @(posedge clk); model_step(); @(negedge clk); compare_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule